// File: doc/BRIEF.md
# Three-Source Multiply-Accumulate Execution Unit

This unit decodes and executes the integer three-operand arithmetic group of a 64-bit load/store instruction set. An instruction word enters with a valid/ready handshake. While the word is on the input, the unit drives three register indices to a combinational register-file read port and takes the returned operand values. A legal instruction starts an iterative multiplier. When that finishes, the unit combines the product with the accumulator operand and returns one result: a 64-bit value, the destination index, a write enable and an illegal-encoding flag.

The supported forms are multiply-accumulate and multiply-deduct at 32 and 64 bits, signed and unsigned widening multiply-accumulate/deduct from 32-bit sources, and signed and unsigned upper-half multiply. An encoding outside that set returns a result with the illegal flag set and no write. The multiplier retires a parameterised number of multiplier bits per cycle, which trades latency against the area of the partial-product array.

Top module: `mac3_exec_unit`

## Requirements
- R1: An instruction is legal only if bits 28:24 equal 11011 and the 7-bit id {bit31, bits30:29, bits23:21, bit15} is one of 0x00, 0x01, 0x40, 0x41, 0x42, 0x43, 0x44, 0x4A, 0x4B or 0x4C. Any other word returns out_valid with out_illegal=1 and out_wen=0.
- R2: Ids 0x00/0x40 return Ra + Rn*Rm and ids 0x01/0x41 return Ra - Rn*Rm. Bit 15 set selects subtraction. All arithmetic wraps modulo 2^64.
- R3: Register index 31 read in the Rn (bits 9:5), Rm (bits 20:16) or Ra (bits 14:10) position gives the value zero, whatever the read port returns.
- R4: Ids 0x42/0x43 sign-extend the low 32 bits of Rn and Rm to 64 bits, and ids 0x4A/0x4B zero-extend them, before the 64-bit multiply-accumulate or multiply-deduct.
- R5: Id 0x44 returns bits 127:64 of the signed 128-bit product Rn*Rm, and id 0x4C returns bits 127:64 of the unsigned product.
- R6: Ids 0x44 and 0x4C are legal only when the Ra field is 31. With any other Ra they are flagged illegal.
- R7: When bit 31 (size) is 0, bits 63:32 of out_data are zero.
- R8: A legal instruction with Rd (bits 4:0) equal to 31 returns out_valid with out_wen=0 and out_illegal=0. Otherwise out_wen=1 and out_rd equals Rd.
- R9: Each accepted instruction yields exactly one single-cycle out_valid pulse. in_ready stays low from the acceptance of a legal instruction until its result is presented. When out_valid is low, out_wen and out_illegal are low.
- R10: Synchronous reset drops out_valid, out_wen and out_illegal, raises in_ready and abandons any operation in flight, so that operation produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word present |
| in_ready | output | 1 | Unit can accept an instruction |
| in_insn | input | 32 | Instruction word |
| rf_rn_idx | output | 5 | Read index for the first multiplicand |
| rf_rm_idx | output | 5 | Read index for the second multiplicand |
| rf_ra_idx | output | 5 | Read index for the accumulator |
| rf_rn_data | input | 64 | Value at rf_rn_idx (combinational) |
| rf_rm_data | input | 64 | Value at rf_rm_idx (combinational) |
| rf_ra_data | input | 64 | Value at rf_ra_idx (combinational) |
| out_valid | output | 1 | Result present for one cycle |
| out_data | output | 64 | Result value |
| out_rd | output | 5 | Destination index |
| out_wen | output | 1 | Result must be written |
| out_illegal | output | 1 | Encoding is not legal |

## Verification
The bench sweeps all 128 operation ids with both an ordinary and a zero accumulator index, and every wrong value of the fixed opcode field. It uses operands at the sign boundaries: the most negative value, all ones, and values whose bit 31 differs from bit 63. A design that extends from the wrong bit, uses an unsigned product for the signed upper half, or skips the narrow zeroing returns a wrong value. A decoder that accepts upper-half multiplies with a real accumulator index, or honours a read of index 31, is caught by the same sweep. Dropped writes to index 31, the busy window and reset in the middle of a multiply are checked at the handshake ports.

// File: rtl/mac3_pkg.sv
package mac3_pkg;

    localparam int XLEN       = 64;
    localparam int IDX_W      = 5;
    localparam int INSN_W     = 32;
    localparam logic [IDX_W-1:0] ZERO_IDX   = 5'd31;
    localparam logic [4:0]       GROUP_CODE = 5'b11011;

    typedef enum logic [2:0] {
        K_MAC   = 3'd0,
        K_SMACL = 3'd1,
        K_UMACL = 3'd2,
        K_SMULH = 3'd3,
        K_UMULH = 3'd4
    } mac3_kind_e;

    typedef struct packed {
        logic             legal;
        mac3_kind_e       kind;
        logic             sub;
        logic             narrow;
        logic [IDX_W-1:0] rd;
        logic [IDX_W-1:0] rn;
        logic [IDX_W-1:0] rm;
        logic [IDX_W-1:0] ra;
    } mac3_dec_t;

    typedef struct packed {
        mac3_kind_e       kind;
        logic             sub;
        logic             narrow;
        logic [IDX_W-1:0] rd;
        logic [XLEN-1:0]  op_a;
        logic [XLEN-1:0]  op_b;
        logic [XLEN-1:0]  addend;
    } mac3_ctx_t;

    function automatic logic [XLEN-1:0] read_or_zero(input logic [IDX_W-1:0] idx,
                                                     input logic [XLEN-1:0]  val);
        return (idx == ZERO_IDX) ? '0 : val;
    endfunction

    function automatic mac3_dec_t decode_word(input logic [INSN_W-1:0] w);
        mac3_dec_t  d;
        logic [6:0] op_id;
        op_id    = {w[31], w[30:29], w[23:21], w[15]};
        d.rd     = w[4:0];
        d.rn     = w[9:5];
        d.ra     = w[14:10];
        d.rm     = w[20:16];
        d.sub    = w[15];
        d.narrow = ~w[31];
        d.kind   = K_MAC;
        d.legal  = 1'b0;
        if (w[28:24] == GROUP_CODE) begin
            case (op_id)
                7'h00, 7'h01, 7'h40, 7'h41: begin
                    d.legal = 1'b1;
                    d.kind  = K_MAC;
                end
                7'h42, 7'h43: begin
                    d.legal = 1'b1;
                    d.kind  = K_SMACL;
                end
                7'h4A, 7'h4B: begin
                    d.legal = 1'b1;
                    d.kind  = K_UMACL;
                end
                7'h44: begin
                    d.legal = (w[14:10] == ZERO_IDX);
                    d.kind  = K_SMULH;
                end
                7'h4C: begin
                    d.legal = (w[14:10] == ZERO_IDX);
                    d.kind  = K_UMULH;
                end
                default: d.legal = 1'b0;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/mac3_decoder.sv
module mac3_decoder
    import mac3_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output mac3_dec_t         dec
);
    always_comb begin
        dec = decode_word(insn);
    end
endmodule

// File: rtl/mac3_operand_prep.sv
module mac3_operand_prep
    import mac3_pkg::*;
(
    input  mac3_dec_t       dec,
    input  logic [XLEN-1:0] rn_data,
    input  logic [XLEN-1:0] rm_data,
    input  logic [XLEN-1:0] ra_data,
    output logic [XLEN-1:0] op_a,
    output logic [XLEN-1:0] op_b,
    output logic [XLEN-1:0] addend
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] rn_v;
    logic [XLEN-1:0] rm_v;

    always_comb begin
        rn_v   = read_or_zero(dec.rn, rn_data);
        rm_v   = read_or_zero(dec.rm, rm_data);
        addend = read_or_zero(dec.ra, ra_data);
        case (dec.kind)
            K_SMACL: begin
                op_a = {{HALF{rn_v[HALF-1]}}, rn_v[HALF-1:0]};
                op_b = {{HALF{rm_v[HALF-1]}}, rm_v[HALF-1:0]};
            end
            K_UMACL: begin
                op_a = {{HALF{1'b0}}, rn_v[HALF-1:0]};
                op_b = {{HALF{1'b0}}, rm_v[HALF-1:0]};
            end
            default: begin
                op_a = rn_v;
                op_b = rm_v;
            end
        endcase
    end
endmodule

// File: rtl/mac3_iter_mul.sv
module mac3_iter_mul #(
    parameter int WIDTH = 64,
    parameter int DIGIT = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [WIDTH-1:0]   mcand_in,
    input  logic [WIDTH-1:0]   mplier_in,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);
    localparam int STEPS = WIDTH / DIGIT;
    localparam int CNT_W = $clog2(STEPS + 1);
    localparam int SUM_W = WIDTH + DIGIT;

    logic [WIDTH-1:0] mcand;
    logic [WIDTH-1:0] hi;
    logic [WIDTH-1:0] lo;
    logic [CNT_W-1:0] cnt;
    logic             running;
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = {{DIGIT{1'b0}}, hi}
            + ({{DIGIT{1'b0}}, mcand} * {{WIDTH{1'b0}}, lo[DIGIT-1:0]});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand   <= '0;
            hi      <= '0;
            cnt     <= '0;
            running <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                mcand   <= mcand_in;
                hi      <= '0;
                cnt     <= CNT_W'(STEPS);
                running <= 1'b1;
            end else if (running) begin
                hi  <= sum[SUM_W-1:DIGIT];
                cnt <= cnt - CNT_W'(1);
                if (cnt == CNT_W'(1)) begin
                    running <= 1'b0;
                    done    <= 1'b1;
                end
            end
        end
    end

    generate
        if (STEPS == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst)          lo <= '0;
                else if (start)   lo <= mplier_in;
                else if (running) lo <= sum[DIGIT-1:0];
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst)          lo <= '0;
                else if (start)   lo <= mplier_in;
                else if (running) lo <= {sum[DIGIT-1:0], lo[WIDTH-1:DIGIT]};
            end
        end
    endgenerate

    assign product = {hi, lo};
endmodule

// File: rtl/mac3_finish.sv
module mac3_finish
    import mac3_pkg::*;
(
    input  mac3_ctx_t         ctx,
    input  logic [2*XLEN-1:0] product,
    output logic [XLEN-1:0]   result
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] low;
    logic [XLEN-1:0] high_u;
    logic [XLEN-1:0] fix_a;
    logic [XLEN-1:0] fix_b;
    logic [XLEN-1:0] acc;

    always_comb begin
        low    = product[XLEN-1:0];
        high_u = product[2*XLEN-1:XLEN];
        fix_a  = ctx.op_a[XLEN-1] ? ctx.op_b : '0;
        fix_b  = ctx.op_b[XLEN-1] ? ctx.op_a : '0;
        acc    = ctx.sub ? (ctx.addend - low) : (ctx.addend + low);
        case (ctx.kind)
            K_SMULH: result = high_u - fix_a - fix_b;
            K_UMULH: result = high_u;
            default: result = ctx.narrow ? {{HALF{1'b0}}, acc[HALF-1:0]} : acc;
        endcase
    end
endmodule

// File: rtl/mac3_exec_unit.sv
module mac3_exec_unit
    import mac3_pkg::*;
#(
    parameter int MUL_DIGIT = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_insn,
    output logic [4:0]  rf_rn_idx,
    output logic [4:0]  rf_rm_idx,
    output logic [4:0]  rf_ra_idx,
    input  logic [63:0] rf_rn_data,
    input  logic [63:0] rf_rm_data,
    input  logic [63:0] rf_ra_data,
    output logic        out_valid,
    output logic [63:0] out_data,
    output logic [4:0]  out_rd,
    output logic        out_wen,
    output logic        out_illegal
);
    mac3_dec_t         dec;
    logic [XLEN-1:0]   op_a;
    logic [XLEN-1:0]   op_b;
    logic [XLEN-1:0]   addend;
    mac3_ctx_t         ctx;
    logic              busy;
    logic              accept;
    logic              start;
    logic              mul_done;
    logic [2*XLEN-1:0] product;
    logic [XLEN-1:0]   fin;

    mac3_decoder u_dec (
        .insn (in_insn),
        .dec  (dec)
    );

    assign rf_rn_idx = dec.rn;
    assign rf_rm_idx = dec.rm;
    assign rf_ra_idx = dec.ra;

    mac3_operand_prep u_prep (
        .dec     (dec),
        .rn_data (rf_rn_data),
        .rm_data (rf_rm_data),
        .ra_data (rf_ra_data),
        .op_a    (op_a),
        .op_b    (op_b),
        .addend  (addend)
    );

    assign in_ready = ~busy;
    assign accept   = in_valid & in_ready;
    assign start    = accept & dec.legal;

    mac3_iter_mul #(
        .WIDTH (XLEN),
        .DIGIT (MUL_DIGIT)
    ) u_mul (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mcand_in  (op_a),
        .mplier_in (op_b),
        .done      (mul_done),
        .product   (product)
    );

    mac3_finish u_fin (
        .ctx     (ctx),
        .product (product),
        .result  (fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx <= '0;
        end else if (start) begin
            ctx.kind   <= dec.kind;
            ctx.sub    <= dec.sub;
            ctx.narrow <= dec.narrow;
            ctx.rd     <= dec.rd;
            ctx.op_a   <= op_a;
            ctx.op_b   <= op_b;
            ctx.addend <= addend;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy        <= 1'b0;
            out_valid   <= 1'b0;
            out_data    <= '0;
            out_rd      <= '0;
            out_wen     <= 1'b0;
            out_illegal <= 1'b0;
        end else begin
            out_valid   <= 1'b0;
            out_wen     <= 1'b0;
            out_illegal <= 1'b0;
            if (accept && !dec.legal) begin
                out_valid   <= 1'b1;
                out_illegal <= 1'b1;
                out_data    <= '0;
                out_rd      <= dec.rd;
            end
            if (start) begin
                busy <= 1'b1;
            end
            if (mul_done) begin
                busy      <= 1'b0;
                out_valid <= 1'b1;
                out_data  <= fin;
                out_rd    <= ctx.rd;
                out_wen   <= (ctx.rd != ZERO_IDX);
            end
        end
    end
endmodule

// File: rtl/mac3_exec_unit_chk.sv
module mac3_exec_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        in_sf,
    input logic        out_valid,
    input logic [31:0] out_data_hi,
    input logic [4:0]  out_rd,
    input logic        out_wen,
    input logic        out_illegal
);
    logic pending;
    logic last_sf;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            last_sf <= 1'b0;
        end else if (in_valid && in_ready) begin
            pending <= 1'b1;
            last_sf <= in_sf;
        end else if (out_valid) begin
            pending <= 1'b0;
        end
    end

    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> !out_wen); // R1

    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_wen && !last_sf) |-> (out_data_hi == 32'd0)); // R7

    AST_ZERO_DEST_DROPPED: assert property (@(posedge clk) disable iff (rst)
        out_wen |-> (out_rd != 5'd31)); // R8

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_wen && !out_illegal)); // R9

    AST_RESULT_HAS_OWNER: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> pending); // R9

    AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
        (pending && !out_valid) |-> !in_ready); // R9

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && in_ready)); // R10
endmodule

bind mac3_exec_unit mac3_exec_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_sf       (in_insn[31]),
    .out_valid   (out_valid),
    .out_data_hi (out_data[63:32]),
    .out_rd      (out_rd),
    .out_wen     (out_wen),
    .out_illegal (out_illegal)
);

// File: tb/mac3_exec_unit_test.sv
module mac3_exec_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_insn = '0;
    logic [4:0]  rf_rn_idx, rf_rm_idx, rf_ra_idx;
    logic [63:0] rf_rn_data, rf_rm_data, rf_ra_data;
    logic        out_valid;
    logic [63:0] out_data;
    logic [4:0]  out_rd;
    logic        out_wen;
    logic        out_illegal;

    logic [63:0] rf [32];
    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    assign rf_rn_data = rf[rf_rn_idx];
    assign rf_rm_data = rf[rf_rm_idx];
    assign rf_ra_data = rf[rf_ra_idx];

    mac3_exec_unit uut (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_insn     (in_insn),
        .rf_rn_idx   (rf_rn_idx),
        .rf_rm_idx   (rf_rm_idx),
        .rf_ra_idx   (rf_ra_idx),
        .rf_rn_data  (rf_rn_data),
        .rf_rm_data  (rf_rm_data),
        .rf_ra_data  (rf_ra_data),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_rd      (out_rd),
        .out_wen     (out_wen),
        .out_illegal (out_illegal)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run exceeded cycle budget (actual %0d expected <150000)", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic logic [31:0] mk(input logic [6:0] id, input logic [4:0] ra,
                                       input logic [4:0] rn, input logic [4:0] rm,
                                       input logic [4:0] rd);
        return {id[6], id[5:4], 5'b11011, id[3:1], rm, id[0], ra, rn, rd};
    endfunction

    function automatic logic [63:0] rd_reg(input logic [4:0] i);
        return (i == 5'd31) ? 64'd0 : rf[i];
    endfunction

    task automatic model(input logic [31:0] w, output logic [63:0] d,
                         output logic wen, output logic ill);
        logic [6:0]           id;
        logic [63:0]          n, m, a, p;
        logic [127:0]         pu;
        logic signed [127:0]  ps;
        logic                 ok;
        id = {w[31], w[30:29], w[23:21], w[15]};
        n  = rd_reg(w[9:5]);
        m  = rd_reg(w[20:16]);
        a  = rd_reg(w[14:10]);
        ok = (w[28:24] == 5'b11011);
        d  = 64'd0;
        case (id)
            7'h42, 7'h43: begin
                n = {{32{n[31]}}, n[31:0]};
                m = {{32{m[31]}}, m[31:0]};
            end
            7'h4A, 7'h4B: begin
                n = {32'd0, n[31:0]};
                m = {32'd0, m[31:0]};
            end
            default: ;
        endcase
        p  = n * m;
        pu = {64'd0, n} * {64'd0, m};
        ps = $signed({{64{n[63]}}, n}) * $signed({{64{m[63]}}, m});
        case (id)
            7'h00, 7'h01, 7'h40, 7'h41, 7'h42, 7'h43, 7'h4A, 7'h4B: begin
                d = id[0] ? (a - p) : (a + p);
                if (!id[6]) d[63:32] = 32'd0;
            end
            7'h44: begin
                d  = ps[127:64];
                ok = ok && (w[14:10] == 5'd31);
            end
            7'h4C: begin
                d  = pu[127:64];
                ok = ok && (w[14:10] == 5'd31);
            end
            default: ok = 1'b0;
        endcase
        ill = !ok;
        wen = ok && (w[4:0] != 5'd31);
    endtask

    task automatic issue(input logic [31:0] w, input string tag);
        logic [63:0] ed;
        logic        ew, ei;
        int          wt;
        model(w, ed, ew, ei);
        wt = 0;
        while (!in_ready && wt < 100) begin @(negedge clk); wt++; end
        in_insn  = w;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        wt = 0;
        while (!out_valid && wt < 100) begin @(negedge clk); wt++; end
        tests++;
        if (!out_valid || out_illegal !== ei || out_wen !== ew || out_rd !== w[4:0]
            || (!ei && out_data !== ed)) begin
            fails++;
            $display("FAIL %s insn=%h: actual v=%b ill=%b wen=%b rd=%0d data=%h expected v=1 ill=%b wen=%b rd=%0d data=%h",
                     tag, w, out_valid, out_illegal, out_wen, out_rd, out_data,
                     ei, ew, w[4:0], ed);
        end
    endtask

    task automatic expect_bit(input logic act, input logic exp, input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [6:0] id, input logic [4:0] ra);
        case (id)
            7'h00, 7'h01: return "R7";
            7'h40, 7'h41: return (ra == 5'd31) ? "R3" : "R2";
            7'h42, 7'h43, 7'h4A, 7'h4B: return "R4";
            7'h44, 7'h4C: return (ra == 5'd31) ? "R5" : "R6";
            default: return "R1";
        endcase
    endfunction

    task automatic load_pattern(input int k);
        for (int i = 0; i < 32; i++) rf[i] = 64'hA5A5_0000_0000_0000 | 64'(i);
        rf[31] = 64'hDEAD_BEEF_CAFE_F00D;
        case (k)
            0: begin
                rf[1] = 64'h0000_0001_FFFF_FFFE;
                rf[2] = 64'hFFFF_FFFF_8000_0003;
                rf[3] = 64'h1234_5678_9ABC_DEF0;
            end
            1: begin
                rf[1] = 64'h8000_0000_0000_0000;
                rf[2] = 64'hFFFF_FFFF_FFFF_FFFF;
                rf[3] = 64'h7FFF_FFFF_FFFF_FFFF;
            end
            default: begin
                rf[1] = 64'h0123_4567_89AB_CDEF;
                rf[2] = 64'hFEDC_BA98_7654_3210;
                rf[3] = 64'hFFFF_FFFF_0000_0001;
            end
        endcase
    endtask

    initial begin
        load_pattern(0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        expect_bit(out_valid, 1'b0, "R10 out_valid after reset");
        expect_bit(in_ready, 1'b1, "R10 in_ready after reset");
        expect_bit(out_wen, 1'b0, "R10 out_wen after reset");
        expect_bit(out_illegal, 1'b0, "R10 out_illegal after reset");

        // R1..R7: sweep every operation id, two accumulator indices, three patterns
        for (int k = 0; k < 3; k++) begin
            load_pattern(k);
            for (int id = 0; id < 128; id++) begin
                issue(mk(7'(id), 5'd3, 5'd1, 5'd2, 5'd4), tag_of(7'(id), 5'd3));
                issue(mk(7'(id), 5'd31, 5'd1, 5'd2, 5'd4), tag_of(7'(id), 5'd31));
            end
        end

        // R1: wrong group code with otherwise legal ids
        load_pattern(0);
        for (int g = 0; g < 32; g++) begin
            logic [31:0] w;
            if (g == 27) continue;
            w = mk(7'h40, 5'd3, 5'd1, 5'd2, 5'd4);
            w[28:24] = 5'(g);
            issue(w, "R1");
        end

        // R3: zero register in multiplicand positions
        for (int k = 0; k < 3; k++) begin
            load_pattern(k);
            issue(mk(7'h40, 5'd3, 5'd31, 5'd2, 5'd5), "R3");
            issue(mk(7'h41, 5'd3, 5'd1, 5'd31, 5'd5), "R3");
            issue(mk(7'h4C, 5'd31, 5'd31, 5'd2, 5'd5), "R3");
            issue(mk(7'h01, 5'd31, 5'd1, 5'd2, 5'd5), "R3");
        end

        // R8: writes to index 31 dropped
        load_pattern(1);
        issue(mk(7'h40, 5'd3, 5'd1, 5'd2, 5'd31), "R8");
        issue(mk(7'h44, 5'd31, 5'd1, 5'd2, 5'd31), "R8");
        issue(mk(7'h4B, 5'd3, 5'd1, 5'd2, 5'd31), "R8");
        issue(mk(7'h45, 5'd3, 5'd1, 5'd2, 5'd31), "R8");

        // R9: busy window and single-cycle result
        load_pattern(2);
        @(negedge clk);
        in_insn  = mk(7'h42, 5'd3, 5'd1, 5'd2, 5'd6);
        in_valid = 1'b1;
        @(negedge clk);
        expect_bit(in_ready, 1'b0, "R9 in_ready low after legal accept");
        begin
            int pulses = 0;
            for (int c = 0; c < 14; c++) begin
                if (out_valid) pulses++;
                if (out_valid) in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b0;
            tests++;
            if (pulses != 1) begin
                fails++;
                $display("FAIL R9 result pulses: actual %0d expected 1", pulses);
            end
        end
        expect_bit(out_valid, 1'b0, "R9 out_valid quiet afterwards");
        expect_bit(out_wen, 1'b0, "R9 out_wen low when idle");

        // R10: reset during a multiply abandons it
        @(negedge clk);
        in_insn  = mk(7'h40, 5'd3, 5'd1, 5'd2, 5'd7);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        begin
            int seen = 0;
            for (int c = 0; c < 20; c++) begin
                if (out_valid) seen++;
                @(negedge clk);
            end
            tests++;
            if (seen != 0) begin
                fails++;
                $display("FAIL R10 result after mid-op reset: actual %0d expected 0", seen);
            end
        end
        expect_bit(in_ready, 1'b1, "R10 in_ready after mid-op reset");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule